// File: doc/BRIEF.md
# CAN Controller Sleep and Wake Manager

This block governs the low-power state of a CAN protocol controller. A register write port carries three control fields: halt, sleep request and bus-wake select. The manager holds these fields and moves between four modes: normal, halt, sleep-pending and sleep. A request for sleep takes effect only when the bus is quiet. While the bus is busy, the request parks the block in the pending mode. From halt, the controller is already detached from the bus, so the request takes effect at once.

Sleep ends in one of two ways. Software can clear the sleep request. When bus-wake is selected, a dominant bit seen on the bus ends sleep automatically. Any dominant bit seen during sleep latches a bus-activity flag, and that flag raises an interrupt request when its enable is set. After either kind of exit, communication stays disabled until eleven consecutive recessive bit times are seen. After a bus-driven wake, the frame that caused the wake is flagged so that it is not stored.

Top module: `can_sleep_ctrl`

## Requirements
- R1: After reset, mode_o is 2'b00 (normal) and comm_en_o, suppress_store_o, wake_flag_o and wake_irq_o are all 0.
- R2: A write of sleep=1 moves mode_o to 2'b11 (sleep) at that clock edge if bus_idle_i is 1. Otherwise mode_o moves to 2'b10 (pending) and stays there until bus_idle_i is 1 at an edge, when it becomes 2'b11.
- R3: A write of halt=1 with sleep=0 gives mode_o 2'b01. From halt, one write of halt=0 and sleep=1 gives sleep directly when bus_disc_i or bus_idle_i is 1.
- R4: A write of sleep=0 while pending or asleep returns mode_o to 2'b00 (or 2'b01 if halt=1 is written). This is the software wake.
- R5: While asleep with bus-wake select set, a dominant bit (bit_tick_i=1 with rx_bit_i=0) returns mode_o to 2'b00 at the next edge and clears the stored sleep request. With the select cleared, mode_o stays 2'b11.
- R6: comm_en_o is 0 in sleep and after reset. It becomes 1 only once 11 bit ticks with rx_bit_i=1 have occurred with no dominant bit and no sleep in between. Any dominant bit drops it at the next edge.
- R7: suppress_store_o rises on a bus-driven wake and falls at the edge after eof_i=1. A software wake leaves it 0.
- R8: wake_flag_o is set by any dominant bit while in sleep, whether or not bus-wake is selected. A write of flag_clr_i=1 clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: wake_irq_o is 1 exactly when wake_flag_o is 1 and irq_en_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write strobe for the control fields |
| ctrl_halt_i | input | 1 | Halt field write data |
| ctrl_sleep_i | input | 1 | Sleep request field write data |
| ctrl_bus_wake_i | input | 1 | Bus-wake select field write data |
| flag_clr_i | input | 1 | Write-one-to-clear for the bus-activity flag |
| irq_en_i | input | 1 | Interrupt enable for the bus-activity flag (1 = enabled) |
| bus_idle_i | input | 1 | The bus is idle |
| bus_disc_i | input | 1 | The controller is detached from the bus |
| rx_bit_i | input | 1 | Received bit level (1 recessive, 0 dominant) |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| eof_i | input | 1 | End-of-frame pulse |
| mode_o | output | 2 | 00 normal, 01 halt, 10 sleep-pending, 11 sleep |
| comm_en_o | output | 1 | Communication enabled |
| suppress_store_o | output | 1 | Do not store the current frame |
| wake_flag_o | output | 1 | Bus-activity flag |
| wake_irq_o | output | 1 | Interrupt request |

## Verification
Two events on the flag can land in the same cycle. A dominant bit during sleep sets the flag, and a software write clears it. The bench drives flag_clr_i and a dominant bit tick in the same cycle and expects wake_flag_o to remain 1. A clear issued alone afterwards must take it to 0. The same stimulus also checks that, with bus-wake unselected, the block stays asleep and suppress_store_o stays low.

// File: rtl/can_sleep_pkg.sv
package can_sleep_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_HALT   = 2'b01,
    MODE_PEND   = 2'b10,
    MODE_SLEEP  = 2'b11
  } mode_e;
endpackage

// File: rtl/can_sleep_fsm.sv
module can_sleep_fsm
  import can_sleep_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  logic  halt_wd_i,
  input  logic  sleep_wd_i,
  input  logic  bwake_wd_i,
  input  logic  bus_idle_i,
  input  logic  bus_disc_i,
  input  logic  dom_bit_i,
  output mode_e mode_o,
  output logic  in_sleep_o,
  output logic  bus_wake_o
);
  logic  halt_q, sleep_q, bwake_q;
  logic  halt_req, sleep_req, quiet;
  mode_e mode_q, mode_d;

  // a write this cycle takes effect at the same edge
  assign halt_req  = we_i ? halt_wd_i  : halt_q;
  assign sleep_req = we_i ? sleep_wd_i : sleep_q;
  assign quiet     = bus_idle_i | ((mode_q == MODE_HALT) & bus_disc_i);
  assign bus_wake_o = (mode_q == MODE_SLEEP) & sleep_req & bwake_q & dom_bit_i;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_NORMAL, MODE_HALT: begin
        if (sleep_req)     mode_d = quiet ? MODE_SLEEP : MODE_PEND;
        else if (halt_req) mode_d = MODE_HALT;
        else               mode_d = MODE_NORMAL;
      end
      MODE_PEND: begin
        if (!sleep_req)    mode_d = halt_req ? MODE_HALT : MODE_NORMAL;
        else if (quiet)    mode_d = MODE_SLEEP;
      end
      MODE_SLEEP: begin
        if (!sleep_req || bus_wake_o) mode_d = halt_req ? MODE_HALT : MODE_NORMAL;
      end
      default: mode_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_NORMAL;
      halt_q  <= 1'b0;
      sleep_q <= 1'b0;
      bwake_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (we_i) begin
        halt_q  <= halt_wd_i;
        bwake_q <= bwake_wd_i;
      end
      if (bus_wake_o) sleep_q <= 1'b0;
      else if (we_i)  sleep_q <= sleep_wd_i;
    end
  end

  assign mode_o     = mode_q;
  assign in_sleep_o = (mode_q == MODE_SLEEP);

  p_defer_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PEND && sleep_req && !bus_idle_i && !bus_disc_i) |=> (mode_q == MODE_PEND));
  p_bus_wake_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wake_o |=> (mode_q != MODE_SLEEP && !sleep_q));
  p_halt_enter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_NORMAL && we_i && halt_wd_i && !sleep_wd_i) |=> (mode_q == MODE_HALT));
endmodule

// File: rtl/can_sleep_recq.sv
module can_sleep_recq #(
  parameter int unsigned REC_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic rx_bit_i,
  input  logic in_sleep_i,
  output logic comm_en_o
);
  localparam int unsigned CNT_W = $clog2(REC_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REC_BITS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (in_sleep_i)                  cnt_q <= '0;
    else if (bit_tick_i && !rx_bit_i)     cnt_q <= '0;
    else if (bit_tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign comm_en_o = (cnt_q == CNT_MAX) & ~in_sleep_i;

  p_dom_kills_comm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_i && !rx_bit_i) |=> !comm_en_o);
  p_comm_rise_on_rec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(comm_en_o) |-> $past(bit_tick_i && rx_bit_i));
endmodule

// File: rtl/can_sleep_wakeflag.sv
module can_sleep_wakeflag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_sleep_i,
  input  logic dom_bit_i,
  input  logic flag_clr_i,
  input  logic irq_en_i,
  input  logic bus_wake_i,
  input  logic eof_i,
  output logic flag_o,
  output logic irq_o,
  output logic suppress_o
);
  logic flag_q, sup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      sup_q  <= 1'b0;
    end else begin
      if (in_sleep_i && dom_bit_i) flag_q <= 1'b1;   // set beats clear
      else if (flag_clr_i)         flag_q <= 1'b0;
      if (bus_wake_i)              sup_q  <= 1'b1;
      else if (eof_i)              sup_q  <= 1'b0;
    end
  end

  assign flag_o     = flag_q;
  assign irq_o      = flag_q & irq_en_i;
  assign suppress_o = sup_q;

  p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sleep_i && dom_bit_i) |=> flag_o);
  p_sup_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wake_i |=> suppress_o);
  p_sup_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_i && !bus_wake_i) |=> !suppress_o);
endmodule

// File: rtl/can_sleep_ctrl.sv
module can_sleep_ctrl
  import can_sleep_pkg::*;
#(
  parameter int unsigned REC_BITS = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic       ctrl_halt_i,
  input  logic       ctrl_sleep_i,
  input  logic       ctrl_bus_wake_i,
  input  logic       flag_clr_i,
  input  logic       irq_en_i,
  input  logic       bus_idle_i,
  input  logic       bus_disc_i,
  input  logic       rx_bit_i,
  input  logic       bit_tick_i,
  input  logic       eof_i,
  output logic [1:0] mode_o,
  output logic       comm_en_o,
  output logic       suppress_store_o,
  output logic       wake_flag_o,
  output logic       wake_irq_o
);
  mode_e mode;
  logic  in_sleep, bus_wake, dom_bit;

  assign dom_bit = bit_tick_i & ~rx_bit_i;

  can_sleep_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we_i),
    .halt_wd_i  (ctrl_halt_i),
    .sleep_wd_i (ctrl_sleep_i),
    .bwake_wd_i (ctrl_bus_wake_i),
    .bus_idle_i (bus_idle_i),
    .bus_disc_i (bus_disc_i),
    .dom_bit_i  (dom_bit),
    .mode_o     (mode),
    .in_sleep_o (in_sleep),
    .bus_wake_o (bus_wake)
  );

  can_sleep_recq #(.REC_BITS(REC_BITS)) u_recq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_i (bit_tick_i),
    .rx_bit_i   (rx_bit_i),
    .in_sleep_i (in_sleep),
    .comm_en_o  (comm_en_o)
  );

  can_sleep_wakeflag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_sleep_i (in_sleep),
    .dom_bit_i  (dom_bit),
    .flag_clr_i (flag_clr_i),
    .irq_en_i   (irq_en_i),
    .bus_wake_i (bus_wake),
    .eof_i      (eof_i),
    .flag_o     (wake_flag_o),
    .irq_o      (wake_irq_o),
    .suppress_o (suppress_store_o)
  );

  assign mode_o = mode;

  p_no_comm_asleep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11) |-> !comm_en_o);
endmodule

// File: tb/can_sleep_ctrl_test.sv
`timescale 1ns/1ps
module can_sleep_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ctrl_we = 0, ctrl_halt = 0, ctrl_sleep = 0, ctrl_bus_wake = 0;
  logic flag_clr = 0, irq_en = 0, bus_idle = 1, bus_disc = 0;
  logic rx_bit = 1, bit_tick = 0, eof = 0;
  logic [1:0] mode;
  logic comm_en, suppress, wflag, wirq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_sleep_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we), .ctrl_halt_i(ctrl_halt),
    .ctrl_sleep_i(ctrl_sleep), .ctrl_bus_wake_i(ctrl_bus_wake), .flag_clr_i(flag_clr),
    .irq_en_i(irq_en), .bus_idle_i(bus_idle), .bus_disc_i(bus_disc), .rx_bit_i(rx_bit),
    .bit_tick_i(bit_tick), .eof_i(eof), .mode_o(mode), .comm_en_o(comm_en),
    .suppress_store_o(suppress), .wake_flag_o(wflag), .wake_irq_o(wirq));

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic h, input logic s, input logic bw);
    ctrl_we = 1; ctrl_halt = h; ctrl_sleep = s; ctrl_bus_wake = bw;
    step();
    ctrl_we = 0;
  endtask

  task automatic tick(input logic lvl);
    bit_tick = 1; rx_bit = lvl;
    step();
    bit_tick = 0; rx_bit = 1;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 2'b00);
    chk("R1 comm_en", {1'b0, comm_en}, 2'b00);
    chk("R1 suppress", {1'b0, suppress}, 2'b00);
    chk("R1 flag/irq", {wflag, wirq}, 2'b00);
  endtask

  task automatic t_recessive();
    for (int i = 0; i < 10; i++) tick(1);
    chk("R6 ten recessive", {1'b0, comm_en}, 2'b00);
    tick(1);
    chk("R6 eleventh recessive", {1'b0, comm_en}, 2'b01);
    for (int i = 0; i < 5; i++) tick(1);
    tick(0);
    chk("R6 dominant drops", {1'b0, comm_en}, 2'b00);
    for (int i = 0; i < 10; i++) tick(1);
    chk("R6 restart ten", {1'b0, comm_en}, 2'b00);
    tick(1);
    chk("R6 restart eleven", {1'b0, comm_en}, 2'b01);
  endtask

  task automatic t_deferred();
    bus_idle = 0;
    wr(0, 1, 0);
    chk("R2 pending", mode, 2'b10);
    step();
    chk("R2 still pending", mode, 2'b10);
    chk("R6 comm kept while pending", {1'b0, comm_en}, 2'b01);
    bus_idle = 1;
    step();
    chk("R2 sleep on idle", mode, 2'b11);
    chk("R6 comm off in sleep", {1'b0, comm_en}, 2'b00);
  endtask

  task automatic t_sw_wake();
    wr(0, 0, 0);
    chk("R4 sw wake", mode, 2'b00);
    chk("R7 no suppress on sw wake", {1'b0, suppress}, 2'b00);
    for (int i = 0; i < 10; i++) tick(1);
    chk("R6 after wake ten", {1'b0, comm_en}, 2'b00);
    tick(1);
    chk("R6 after wake eleven", {1'b0, comm_en}, 2'b01);
  endtask

  task automatic t_halt_seq();
    wr(1, 0, 0);
    chk("R3 halt", mode, 2'b01);
    bus_idle = 0; bus_disc = 1;
    wr(0, 1, 0);
    chk("R3 halt->sleep in one write", mode, 2'b11);
    bus_disc = 0; bus_idle = 1;
  endtask

  task automatic t_flag_race();
    irq_en = 0;
    tick(0);
    chk("R5 no bus wake when unselected", mode, 2'b11);
    chk("R8 flag set", {1'b0, wflag}, 2'b01);
    chk("R9 irq masked", {1'b0, wirq}, 2'b00);
    chk("R7 no suppress", {1'b0, suppress}, 2'b00);
    irq_en = 1; #1;
    chk("R9 irq enabled", {1'b0, wirq}, 2'b01);
    flag_clr = 1; bit_tick = 1; rx_bit = 0;
    step();
    flag_clr = 0; bit_tick = 0; rx_bit = 1;
    chk("R8 set beats clear", {1'b0, wflag}, 2'b01);
    flag_clr = 1;
    step();
    flag_clr = 0;
    chk("R8 clear", {wflag, wirq}, 2'b00);
  endtask

  task automatic t_bus_wake();
    wr(0, 1, 1);
    chk("R5 sleep with bus wake", mode, 2'b11);
    tick(0);
    chk("R5 bus wake", mode, 2'b00);
    chk("R7 suppress set", {1'b0, suppress}, 2'b01);
    chk("R8 flag on wake", {1'b0, wflag}, 2'b01);
    step(); step();
    chk("R5 sleep bit cleared", mode, 2'b00);
    chk("R7 suppress held", {1'b0, suppress}, 2'b01);
    eof = 1;
    step();
    eof = 0;
    chk("R7 suppress off at eof", {1'b0, suppress}, 2'b00);
    for (int i = 0; i < 11; i++) tick(1);
    chk("R6 comm after bus wake", {1'b0, comm_en}, 2'b01);
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_ni = 1;
    step();
    t_reset();
    t_recessive();
    t_deferred();
    t_sw_wake();
    t_halt_seq();
    t_flag_race();
    t_bus_wake();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule